// File: doc/BRIEF.md
# Thirty-Two Line GPIO Bank with Twin Interrupt Outputs

This block is one bank of 32 general-purpose pins behind a simple 32-bit register bus. Software uses the bus to do four things:

- pick, per pin, whether the pin is an input or is driven;
- write or sample the pin values;
- set up edge and level detection on the input pins;
- route detected events to two separate interrupt outputs and to a wakeup request.

A single detected event sets the pin's bit in both status words at once. Each interrupt output then applies its own enable mask, so two different consumers can service the same bank on their own terms.

The bus accepts byte, halfword and word accesses. For ordinary storage registers, a narrow write merges the written lanes into the current contents. For write-1-to-clear status words and for the set and clear aliases, the lanes that are not written count as zero. A narrow read returns the addressed word shifted right by eight times the byte offset.

A configuration register has two jobs:

- it holds a soft-reset trigger;
- it holds the bits that gate the wakeup path.

Debounce settings are held as plain storage and have no timing effect.

Top module: `gpio_bank32`

## Requirements
- R1: After reset the control word reads 2, output enable reads all ones, the system status word (0x14) reads 1, and the revision word (0x00) reads the REV_ID parameter. Configuration, status, enables, wake enable, detect selects, debounce words and data out all read 0.
- R2: `pin_out` carries the data-out register (0x3C). `pin_out_en` is high exactly for the bits whose output-enable bit (0x34) is 0; a 1 in output enable makes the pin an input.
- R3: On an input pin, a 0-to-1 change with its rising select (0x48) set, or a 1-to-0 change with its falling select (0x4C) set, sets that bit in both status words (0x18 and 0x28). The bit is set at the clock edge that samples the change.
- R4: On an input pin, a high level with its level-high select (0x44) set, or a low level with its level-low select (0x40) set, sets the status bit on every cycle the level lasts. A clear applied while the level is still present leaves the bit set.
- R5: Writing 1s to a status word clears exactly those bits and leaves the other status word alone. Writing 0s changes nothing.
- R6: `irq_a` is high while status 1 ANDed with enable 1 (0x1C) is nonzero. `irq_b` is the same function of status 2 and enable 2 (0x2C).
- R7: Aliases clear or set bits without touching the others: enable 1 at 0x60/0x64, enable 2 at 0x70/0x74, wake enable at 0x80/0x84, data out at 0x90/0x94 (the lower offset clears). Reading an alias returns the underlying register.
- R8: `bus_size` is 0 for a byte, 1 for a halfword, and 2 or 3 for a word; word accesses ignore `bus_addr[1:0]`. A narrow write keeps the unwritten lanes of an ordinary register. For status words and aliases the unwritten lanes act as zero.
- R9: A narrow read returns the addressed word shifted right by 8 times `bus_addr[1:0]`, with no masking of the upper bits.
- R10: A configuration write (0x10) stores the written value ANDed with 0x1D. If bit 1 of that write is 1, the bank first returns every register except data out and data in to its reset value. The control word (0x30) keeps 3 bits.
- R11: `wake_req` is high in the cycle after an event only when configuration bit 2 is 1, configuration bits 4:3 are nonzero, and the pin's wake-enable bit (0x20) is 1.
- R12: Data in (0x38) reads the pin inputs as sampled one clock earlier. Writes to 0x00, 0x14, 0x38 and to undefined offsets change nothing.
- R13: A pin configured as an output never raises an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address within the bank |
| bus_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| bus_wdata | input | 32 | Write data, right-justified |
| bus_rdata | output | 32 | Read data, zero when not selected |
| pin_in | input | 32 | Pin input levels |
| pin_out | output | 32 | Pin output values |
| pin_out_en | output | 32 | 1 where the pin is driven |
| irq_a | output | 1 | First interrupt output |
| irq_b | output | 1 | Second interrupt output |
| wake_req | output | 1 | Wakeup request |

## Verification
The bench targets the following corner cases, each with the failure it would expose:

- **Byte write to a status word.** A design that merged unwritten lanes from the current value would also clear bit 0, which is set and sits in the unwritten lane.
- **Byte write to a clear alias.** A design that merged lanes would wipe the enable bits in the other lanes.
- **Clearing a status bit whose level condition is still true.** A design that applied the clear after the event would drop the bit even though the level persists.
- **Toggling a pin set as an output.** A design that ignored the direction bit would report a spurious event.
- **The wake path with each gating condition removed in turn.** A missing qualifier would show up as a wake pulse where none is allowed.
- **Soft reset.** The bench checks that enables and direction return to their reset values while the configuration keeps its masked new value.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
package gpio_bank_pkg;

  localparam int LINES     = 32;
  localparam int BYTE_BITS = 8;

  typedef logic [LINES-1:0] lines_t;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WRD2 = 2'd3
  } acc_size_e;

  // register word offsets (byte addresses, low two bits zero)
  localparam logic [7:0] OFF_REV      = 8'h00;
  localparam logic [7:0] OFF_SYSCFG   = 8'h10;
  localparam logic [7:0] OFF_SYSSTAT  = 8'h14;
  localparam logic [7:0] OFF_STAT1    = 8'h18;
  localparam logic [7:0] OFF_EN1      = 8'h1C;
  localparam logic [7:0] OFF_WKEN     = 8'h20;
  localparam logic [7:0] OFF_STAT2    = 8'h28;
  localparam logic [7:0] OFF_EN2      = 8'h2C;
  localparam logic [7:0] OFF_CTRL     = 8'h30;
  localparam logic [7:0] OFF_OE       = 8'h34;
  localparam logic [7:0] OFF_DIN      = 8'h38;
  localparam logic [7:0] OFF_DOUT     = 8'h3C;
  localparam logic [7:0] OFF_LVL_LO   = 8'h40;
  localparam logic [7:0] OFF_LVL_HI   = 8'h44;
  localparam logic [7:0] OFF_RISE     = 8'h48;
  localparam logic [7:0] OFF_FALL     = 8'h4C;
  localparam logic [7:0] OFF_DB_EN    = 8'h50;
  localparam logic [7:0] OFF_DB_TIME  = 8'h54;
  localparam logic [7:0] OFF_EN1_CLR  = 8'h60;
  localparam logic [7:0] OFF_EN1_SET  = 8'h64;
  localparam logic [7:0] OFF_EN2_CLR  = 8'h70;
  localparam logic [7:0] OFF_EN2_SET  = 8'h74;
  localparam logic [7:0] OFF_WKEN_CLR = 8'h80;
  localparam logic [7:0] OFF_WKEN_SET = 8'h84;
  localparam logic [7:0] OFF_DOUT_CLR = 8'h90;
  localparam logic [7:0] OFF_DOUT_SET = 8'h94;

  // configuration word layout
  localparam int         CFG_W        = 5;
  localparam int         CFG_SRST_BIT = 1;
  localparam int         CFG_WAKE_BIT = 2;
  localparam int         CFG_IDLE_LO  = 3;
  localparam int         CFG_IDLE_HI  = 4;
  localparam logic [CFG_W-1:0] CFG_KEEP = 5'h1D;
  localparam int         CTRL_W       = 3;
  localparam logic [CTRL_W-1:0] CTRL_RST = 3'd2;
  localparam int         DBT_W        = 8;

  // byte offset that actually applies: word accesses are aligned
  function automatic logic [1:0] eff_offset(input logic [1:0] sz, input logic [1:0] off);
    return (sz[1]) ? 2'd0 : off;
  endfunction

  function automatic lines_t lane_mask(input logic [1:0] sz, input logic [1:0] off);
    lines_t base;
    case (sz)
      SZ_BYTE: base = lines_t'(32'h0000_00FF);
      SZ_HALF: base = lines_t'(32'h0000_FFFF);
      default: base = '1;
    endcase
    return base << {eff_offset(sz, off), 3'b000};
  endfunction

  function automatic lines_t lane_place(input lines_t data, input logic [1:0] sz,
                                        input logic [1:0] off);
    return (data << {eff_offset(sz, off), 3'b000}) & lane_mask(sz, off);
  endfunction

  function automatic lines_t read_align(input lines_t word, input logic [1:0] sz,
                                        input logic [1:0] off);
    return word >> {eff_offset(sz, off), 3'b000};
  endfunction

  function automatic lines_t merge_lanes(input lines_t cur, input lines_t val,
                                         input lines_t bm);
    return (cur & ~bm) | (val & bm);
  endfunction

  // edges compare the live pin with last sample; levels use the sample
  function automatic lines_t pin_events(input lines_t live, input lines_t smp,
                                        input lines_t is_in, input lines_t rise,
                                        input lines_t fall, input lines_t lo,
                                        input lines_t hi);
    lines_t edge_hit, lvl_hit;
    edge_hit = (live & ~smp & rise) | (~live & smp & fall);
    lvl_hit  = (smp & hi) | (~smp & lo);
    return is_in & (edge_hit | lvl_hit);
  endfunction

endpackage

// File: rtl/gpio_lane_align.sv
`timescale 1ns/1ps
module gpio_lane_align
  import gpio_bank_pkg::*;
(
  input  logic [1:0] acc_size,
  input  logic [1:0] acc_off,
  input  lines_t     wdata_raw,
  input  lines_t     rword,
  output lines_t     wr_mask,
  output lines_t     wr_val,
  output lines_t     rd_data
);
  always_comb begin
    wr_mask = lane_mask(acc_size, acc_off);
    wr_val  = lane_place(wdata_raw, acc_size, acc_off);
    rd_data = read_align(rword, acc_size, acc_off);
  end
endmodule

// File: rtl/gpio_pin_detect.sv
`timescale 1ns/1ps
module gpio_pin_detect
  import gpio_bank_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  lines_t pin_in,
  input  lines_t dir_in,
  input  lines_t rise_sel,
  input  lines_t fall_sel,
  input  lines_t lo_sel,
  input  lines_t hi_sel,
  output lines_t sampled,
  output lines_t events
);
  lines_t smp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smp_q <= '0;
    else        smp_q <= pin_in;
  end

  assign sampled = smp_q;

  always_comb begin
    events = pin_events(pin_in, smp_q, dir_in, rise_sel, fall_sel, lo_sel, hi_sel);
  end
endmodule

// File: rtl/gpio_regs.sv
`timescale 1ns/1ps
module gpio_regs
  import gpio_bank_pkg::*;
#(
  parameter logic [7:0] REV_ID = 8'h18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        word_addr,
  input  lines_t            wr_mask,
  input  lines_t            wr_val,
  input  lines_t            evt,
  input  lines_t            din,
  output lines_t            oe,
  output lines_t            dout,
  output lines_t            rise_sel,
  output lines_t            fall_sel,
  output lines_t            lo_sel,
  output lines_t            hi_sel,
  output lines_t            en1,
  output lines_t            en2,
  output lines_t            wken,
  output lines_t            stat1,
  output lines_t            stat2,
  output logic [CFG_W-1:0]  cfg,
  output lines_t            clr1,
  output logic              soft_rst,
  output lines_t            rword
);
  lines_t              oe_q, dout_q, rise_q, fall_q, lo_q, hi_q;
  lines_t              en1_q, en2_q, wken_q, stat1_q, stat2_q, dben_q;
  logic [DBT_W-1:0]    dbt_q;
  logic [CFG_W-1:0]    cfg_q;
  logic [CTRL_W-1:0]   ctrl_q;
  lines_t              merged, alias_v, clr2;

  // read mux; aliases return their underlying register
  always_comb begin
    case (word_addr)
      OFF_REV:                                rword = lines_t'(REV_ID);
      OFF_SYSCFG:                             rword = lines_t'(cfg_q);
      OFF_SYSSTAT:                            rword = lines_t'(1);
      OFF_STAT1:                              rword = stat1_q;
      OFF_EN1, OFF_EN1_CLR, OFF_EN1_SET:      rword = en1_q;
      OFF_WKEN, OFF_WKEN_CLR, OFF_WKEN_SET:   rword = wken_q;
      OFF_STAT2:                              rword = stat2_q;
      OFF_EN2, OFF_EN2_CLR, OFF_EN2_SET:      rword = en2_q;
      OFF_CTRL:                               rword = lines_t'(ctrl_q);
      OFF_OE:                                 rword = oe_q;
      OFF_DIN:                                rword = din;
      OFF_DOUT, OFF_DOUT_CLR, OFF_DOUT_SET:   rword = dout_q;
      OFF_LVL_LO:                             rword = lo_q;
      OFF_LVL_HI:                             rword = hi_q;
      OFF_RISE:                               rword = rise_q;
      OFF_FALL:                               rword = fall_q;
      OFF_DB_EN:                              rword = dben_q;
      OFF_DB_TIME:                            rword = lines_t'(dbt_q);
      default:                                rword = '0;
    endcase
  end

  // ordinary registers merge with current contents; aliases and status
  // words see the unwritten lanes as zero
  always_comb begin
    merged   = merge_lanes(rword, wr_val, wr_mask);
    alias_v  = wr_val & wr_mask;
    clr1     = (wr_en && word_addr == OFF_STAT1) ? alias_v : '0;
    clr2     = (wr_en && word_addr == OFF_STAT2) ? alias_v : '0;
    soft_rst = wr_en && (word_addr == OFF_SYSCFG) && merged[CFG_SRST_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q    <= '1;  dout_q <= '0;  rise_q <= '0;  fall_q <= '0;
      lo_q    <= '0;  hi_q   <= '0;  en1_q  <= '0;  en2_q  <= '0;
      wken_q  <= '0;  stat1_q <= '0; stat2_q <= '0; dben_q <= '0;
      dbt_q   <= '0;  cfg_q  <= '0;  ctrl_q <= CTRL_RST;
    end else if (soft_rst) begin
      oe_q    <= '1;  rise_q <= '0;  fall_q <= '0;
      lo_q    <= '0;  hi_q   <= '0;  en1_q  <= '0;  en2_q  <= '0;
      wken_q  <= '0;  stat1_q <= '0; stat2_q <= '0; dben_q <= '0;
      dbt_q   <= '0;  ctrl_q <= CTRL_RST;
      cfg_q   <= merged[CFG_W-1:0] & CFG_KEEP;
    end else begin
      // clear first, then OR in events so a live level sets the bit again
      stat1_q <= (stat1_q & ~clr1) | evt;
      stat2_q <= (stat2_q & ~clr2) | evt;
      if (wr_en) begin
        case (word_addr)
          OFF_SYSCFG:   cfg_q  <= merged[CFG_W-1:0] & CFG_KEEP;
          OFF_EN1:      en1_q  <= merged;
          OFF_EN1_CLR:  en1_q  <= en1_q & ~alias_v;
          OFF_EN1_SET:  en1_q  <= en1_q | alias_v;
          OFF_EN2:      en2_q  <= merged;
          OFF_EN2_CLR:  en2_q  <= en2_q & ~alias_v;
          OFF_EN2_SET:  en2_q  <= en2_q | alias_v;
          OFF_WKEN:     wken_q <= merged;
          OFF_WKEN_CLR: wken_q <= wken_q & ~alias_v;
          OFF_WKEN_SET: wken_q <= wken_q | alias_v;
          OFF_CTRL:     ctrl_q <= merged[CTRL_W-1:0];
          OFF_OE:       oe_q   <= merged;
          OFF_DOUT:     dout_q <= merged;
          OFF_DOUT_CLR: dout_q <= dout_q & ~alias_v;
          OFF_DOUT_SET: dout_q <= dout_q | alias_v;
          OFF_LVL_LO:   lo_q   <= merged;
          OFF_LVL_HI:   hi_q   <= merged;
          OFF_RISE:     rise_q <= merged;
          OFF_FALL:     fall_q <= merged;
          OFF_DB_EN:    dben_q <= merged;
          OFF_DB_TIME:  dbt_q  <= merged[DBT_W-1:0];
          default: ;
        endcase
      end
    end
  end

  assign oe       = oe_q;
  assign dout     = dout_q;
  assign rise_sel = rise_q;
  assign fall_sel = fall_q;
  assign lo_sel   = lo_q;
  assign hi_sel   = hi_q;
  assign en1      = en1_q;
  assign en2      = en2_q;
  assign wken     = wken_q;
  assign stat1    = stat1_q;
  assign stat2    = stat2_q;
  assign cfg      = cfg_q;
endmodule

// File: rtl/gpio_irq_wake.sv
`timescale 1ns/1ps
module gpio_irq_wake
  import gpio_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  lines_t           stat1,
  input  lines_t           en1,
  input  lines_t           stat2,
  input  lines_t           en2,
  input  lines_t           evt,
  input  lines_t           wken,
  input  logic [CFG_W-1:0] cfg,
  input  logic             soft_rst,
  output logic             irq_a,
  output logic             irq_b,
  output logic             wake_req
);
  logic wake_q, wake_gate;

  assign irq_a     = |(stat1 & en1);
  assign irq_b     = |(stat2 & en2);
  assign wake_gate = cfg[CFG_WAKE_BIT] && (cfg[CFG_IDLE_HI:CFG_IDLE_LO] != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wake_q <= 1'b0;
    else if (soft_rst) wake_q <= 1'b0;
    else               wake_q <= wake_gate && |(evt & wken);
  end

  assign wake_req = wake_q;
endmodule

// File: rtl/gpio_bank32.sv
`timescale 1ns/1ps
module gpio_bank32
  import gpio_bank_pkg::*;
#(
  parameter logic [7:0] REV_ID = 8'h18
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [1:0]  bus_size,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [31:0] pin_in,
  output logic [31:0] pin_out,
  output logic [31:0] pin_out_en,
  output logic        irq_a,
  output logic        irq_b,
  output logic        wake_req
);
  // internal events brought out by name for the checker
  lines_t           evt_w, din_w, oe_w, dout_w, rise_w, fall_w, lo_w, hi_w;
  lines_t           en1_w, en2_w, wken_w, stat1_w, stat2_w, clr1_w;
  lines_t           wmask_w, wval_w, rword_w, rdata_w;
  logic [CFG_W-1:0] cfg_w;
  logic             soft_rst_w, wr_en_w;
  logic [7:0]       waddr_w;

  assign wr_en_w = bus_sel & bus_wr;
  assign waddr_w = {bus_addr[7:2], 2'b00};

  gpio_lane_align u_lanes (
    .acc_size (bus_size),
    .acc_off  (bus_addr[1:0]),
    .wdata_raw(bus_wdata),
    .rword    (rword_w),
    .wr_mask  (wmask_w),
    .wr_val   (wval_w),
    .rd_data  (rdata_w)
  );

  gpio_pin_detect u_detect (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_in  (pin_in),
    .dir_in  (oe_w),
    .rise_sel(rise_w),
    .fall_sel(fall_w),
    .lo_sel  (lo_w),
    .hi_sel  (hi_w),
    .sampled (din_w),
    .events  (evt_w)
  );

  gpio_regs #(.REV_ID(REV_ID)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en_w),
    .word_addr(waddr_w),
    .wr_mask  (wmask_w),
    .wr_val   (wval_w),
    .evt      (evt_w),
    .din      (din_w),
    .oe       (oe_w),
    .dout     (dout_w),
    .rise_sel (rise_w),
    .fall_sel (fall_w),
    .lo_sel   (lo_w),
    .hi_sel   (hi_w),
    .en1      (en1_w),
    .en2      (en2_w),
    .wken     (wken_w),
    .stat1    (stat1_w),
    .stat2    (stat2_w),
    .cfg      (cfg_w),
    .clr1     (clr1_w),
    .soft_rst (soft_rst_w),
    .rword    (rword_w)
  );

  gpio_irq_wake u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .stat1   (stat1_w),
    .en1     (en1_w),
    .stat2   (stat2_w),
    .en2     (en2_w),
    .evt     (evt_w),
    .wken    (wken_w),
    .cfg     (cfg_w),
    .soft_rst(soft_rst_w),
    .irq_a   (irq_a),
    .irq_b   (irq_b),
    .wake_req(wake_req)
  );

  assign bus_rdata  = bus_sel ? rdata_w : '0;
  assign pin_out    = dout_w;
  assign pin_out_en = ~oe_w;
endmodule

// File: rtl/gpio_bank32_checker.sv
`timescale 1ns/1ps
module gpio_bank32_checker
  import gpio_bank_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input lines_t           evt,
  input lines_t           oe,
  input lines_t           stat1,
  input lines_t           stat2,
  input lines_t           clr1,
  input logic             soft_rst,
  input logic [CFG_W-1:0] cfg,
  input logic             wake_req,
  input logic             irq_a,
  input logic             irq_b
);
  // R1: a soft reset leaves cleared status and all-input direction
  assert_soft_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(soft_rst) |-> (stat1 == '0 && stat2 == '0 && oe == '1));

  // R3: every event lands in both status words
  assert_both_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0 && !soft_rst) |=> ((stat1 & stat2 & $past(evt)) == $past(evt)));

  // R5: without a clear, set status bits stay set
  assert_status_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr1 == '0 && !soft_rst) |=> ((stat1 & $past(stat1)) == $past(stat1)));

  // R13: output pins raise no events
  assert_no_output_event_R13: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt & ~oe) == '0));

  // R11: wake only follows a cycle where the configuration allowed it
  assert_wake_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> $past(cfg[CFG_WAKE_BIT] && cfg[CFG_IDLE_HI:CFG_IDLE_LO] != 2'b00));

  // R6: an interrupt needs pending status behind it
  assert_irq_a_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_a |-> (stat1 != '0));
  assert_irq_b_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_b |-> (stat2 != '0));
endmodule

bind gpio_bank32 gpio_bank32_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .evt     (evt_w),
  .oe      (oe_w),
  .stat1   (stat1_w),
  .stat2   (stat2_w),
  .clr1    (clr1_w),
  .soft_rst(soft_rst_w),
  .cfg     (cfg_w),
  .wake_req(wake_req),
  .irq_a   (irq_a),
  .irq_b   (irq_b)
);

// File: tb/gpio_bank32_bench.sv
`timescale 1ns/1ps
module gpio_bank32_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [1:0]  bus_size = 2'd2;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_out_en;
  logic        irq_a, irq_b, wake_req;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  localparam logic [1:0] B = 2'd0, H = 2'd1, W = 2'd2;

  always #5 clk = ~clk;

  gpio_bank32 u_gpio_bank32 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_out_en(pin_out_en), .irq_a(irq_a), .irq_b(irq_b), .wake_req(wake_req)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_size = sz; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [1:0] sz,
                        input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_size = sz;
    #1;
    check(tag, bus_rdata, exp);
    bus_sel = 1'b0;
  endtask

  task automatic pins(input logic [31:0] v);
    @(negedge clk);
    pin_in = v;
  endtask

  task automatic clear_all();
    wr(8'h18, W, 32'hFFFF_FFFF);
    wr(8'h28, W, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    rd_chk(8'h00, W, 32'h18, "R1 revision");
    rd_chk(8'h14, W, 32'h1, "R1 sysstatus");
    rd_chk(8'h30, W, 32'h2, "R1 control");
    rd_chk(8'h34, W, 32'hFFFF_FFFF, "R1 output enable");
    rd_chk(8'h18, W, 32'h0, "R1 status1");
    rd_chk(8'h28, W, 32'h0, "R1 status2");
    rd_chk(8'h1C, W, 32'h0, "R1 enable1");
    rd_chk(8'h10, W, 32'h0, "R1 config");
    rd_chk(8'h3C, W, 32'h0, "R1 data out");
    check("R1 pin_out_en", pin_out_en, 32'h0);
    check("R1 irq_a", {31'b0, irq_a}, 32'h0);
  endtask

  task automatic t_edges();
    wr(8'h48, W, 32'h5);
    wr(8'h4C, W, 32'h2);
    wr(8'h34, W, ~32'h4);
    check("R2 pin_out_en follows direction", pin_out_en, 32'h4);
    pins(32'h7);
    rd_chk(8'h18, W, 32'h1, "R3/R13 rising into status1");
    rd_chk(8'h28, W, 32'h1, "R3 rising into status2");
    pins(32'h0);
    rd_chk(8'h18, W, 32'h3, "R3 falling into status1");
    rd_chk(8'h28, W, 32'h3, "R3 falling into status2");
    wr(8'h34, W, 32'hFFFF_FFFF);
    wr(8'h48, W, 32'h0);
    wr(8'h4C, W, 32'h0);
  endtask

  task automatic t_w1c_irq();
    wr(8'h18, W, 32'h1);
    rd_chk(8'h18, W, 32'h2, "R5 w1c clears bit 0 only");
    rd_chk(8'h28, W, 32'h3, "R5 status2 untouched");
    wr(8'h18, W, 32'h0);
    rd_chk(8'h18, W, 32'h2, "R5 zero write no effect");
    wr(8'h64, W, 32'h2);
    check("R6 irq_a on", {31'b0, irq_a}, 32'h1);
    check("R6 irq_b off", {31'b0, irq_b}, 32'h0);
    wr(8'h74, W, 32'h1);
    check("R6 irq_b on", {31'b0, irq_b}, 32'h1);
    rd_chk(8'h70, W, 32'h1, "R7 enable2 via alias");
    rd_chk(8'h60, W, 32'h2, "R7 enable1 via alias");
    wr(8'h28, W, 32'h3);
    check("R6 irq_b drops", {31'b0, irq_b}, 32'h0);
    check("R6 irq_a stays", {31'b0, irq_a}, 32'h1);
    wr(8'h60, W, 32'h2);
    check("R6 irq_a masked", {31'b0, irq_a}, 32'h0);
    clear_all();
    wr(8'h70, W, 32'hFFFF_FFFF);
  endtask

  task automatic t_alias_narrow();
    wr(8'h94, W, 32'hF0);
    wr(8'h90, W, 32'h30);
    rd_chk(8'h3C, W, 32'hC0, "R7 data out set/clear");
    check("R2 pin_out", pin_out, 32'hC0);
    wr(8'h3C, W, 32'h1234_5678);
    wr(8'h3D, B, 32'hAB);
    rd_chk(8'h3C, W, 32'h1234_AB78, "R8 byte merge");
    wr(8'h3E, H, 32'hBEEF);
    rd_chk(8'h3C, W, 32'hBEEF_AB78, "R8 half merge");
    rd_chk(8'h3D, B, 32'h00BE_EFAB, "R9 byte read shift");
    rd_chk(8'h3E, H, 32'h0000_BEEF, "R9 half read shift");
    wr(8'h48, W, 32'h101);
    pins(32'h101);
    rd_chk(8'h18, W, 32'h101, "R3 two rising edges");
    wr(8'h19, B, 32'h01);
    rd_chk(8'h18, W, 32'h001, "R8 narrow w1c zero lanes");
    pins(32'h0);
    wr(8'h48, W, 32'h0);
    clear_all();
    wr(8'h64, W, 32'h101);
    wr(8'h61, B, 32'h01);
    rd_chk(8'h1C, W, 32'h001, "R8 narrow clear alias");
    wr(8'h60, W, 32'hFFFF_FFFF);
  endtask

  task automatic t_level();
    wr(8'h44, W, 32'h20);
    pins(32'h20);
    @(negedge clk);
    rd_chk(8'h18, W, 32'h20, "R4 level high sets");
    wr(8'h18, W, 32'h20);
    rd_chk(8'h18, W, 32'h20, "R4 clear re-sets under level");
    wr(8'h44, W, 32'h0);
    wr(8'h18, W, 32'h20);
    rd_chk(8'h18, W, 32'h0, "R4 clear holds once level off");
    wr(8'h40, W, 32'h40);
    rd_chk(8'h18, W, 32'h40, "R4 level low sets");
    wr(8'h40, W, 32'h0);
    clear_all();
    rd_chk(8'h28, W, 32'h0, "R4 status2 cleared");
  endtask

  task automatic t_sysconfig();
    wr(8'h1C, W, 32'h3);
    wr(8'h34, W, 32'h0F0F_0F0F);
    wr(8'h30, W, 32'h5);
    wr(8'h10, W, 32'hFF);
    rd_chk(8'h10, W, 32'h1D, "R10 config masked");
    rd_chk(8'h1C, W, 32'h0, "R10 soft reset enable1");
    rd_chk(8'h34, W, 32'hFFFF_FFFF, "R10 soft reset direction");
    rd_chk(8'h30, W, 32'h2, "R10 soft reset control");
    wr(8'h30, W, 32'hFF);
    rd_chk(8'h30, W, 32'h7, "R10 control 3 bits");
    wr(8'h10, W, 32'h0C);
    rd_chk(8'h10, W, 32'h0C, "R10 plain config write");
  endtask

  task automatic rise_wake(input logic exp, input string tag);
    pins(32'h0);
    pins(32'h1);
    @(negedge clk); #1;
    check(tag, {31'b0, wake_req}, {31'b0, exp});
    @(negedge clk); #1;
    check({tag, " then low"}, {31'b0, wake_req}, 32'h0);
  endtask

  task automatic t_wake();
    pins(32'h0);
    wr(8'h84, W, 32'h1);
    wr(8'h48, W, 32'h1);
    rise_wake(1'b1, "R11 wake pulse");
    wr(8'h10, W, 32'h04);
    rise_wake(1'b0, "R11 no wake with idle field zero");
    wr(8'h10, W, 32'h08);
    rise_wake(1'b0, "R11 no wake with enable bit clear");
    wr(8'h10, W, 32'h0C);
    wr(8'h80, W, 32'h1);
    rise_wake(1'b0, "R11 no wake with pin disabled");
    wr(8'h48, W, 32'h0);
    clear_all();
  endtask

  task automatic t_readonly();
    pins(32'hA5A5_0001);
    @(negedge clk);
    rd_chk(8'h38, W, 32'hA5A5_0001, "R12 data in");
    wr(8'h38, W, 32'h0);
    wr(8'h00, W, 32'h0);
    wr(8'h14, W, 32'h0);
    wr(8'h58, W, 32'hFFFF_FFFF);
    rd_chk(8'h38, W, 32'hA5A5_0001, "R12 data in unwritable");
    rd_chk(8'h00, W, 32'h18, "R12 revision unwritable");
    rd_chk(8'h14, W, 32'h1, "R12 sysstatus unwritable");
    rd_chk(8'h34, W, 32'hFFFF_FFFF, "R12 undefined write ignored");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_edges();
    t_w1c_irq();
    t_alias_narrow();
    t_level();
    t_sysconfig();
    t_wake();
    t_readonly();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule